// File: doc/BRIEF.md
# SD Port Switch and Card Reader Mode Control

This block holds a single byte-wide control register that steers two SD port switch banks and selects how the SD cards reach the USB side. Software writes the register over a simple byte bus at address 0x00 and can read it back. From the stored bits the block works out three things: the switch-enable level driven to each port, which card (if any) is routed to USB, and the operating mode (pass-through, card reader or sleep).

When a card is routed to USB, the switch bit of that card's port is overridden and forced off. The other port stays under register control. A card selection written while the sleep bit is set does not start card-reader mode. The block keeps the selection and applies it on the first clock edge after the sleep bit clears. Switch bits take effect straight away in every mode.

Register layout: bit 0 enables the port 1 switches, bit 1 enables the port 2 switches, bits 3:2 select the card routed to USB (00 none, 01 card 1, 10 card 2, 11 reserved), and bit 7 requests sleep. Bits 6:4 are not stored.

Top module: `cr_mode_ctl`

## Requirements
- R1: After reset the stored register is 0x00. Both switch enables are 0, `opMode` is 2'b00 and `usbRoute` is 2'b00.
- R2: Only address 0x00 is decoded. A write to any other address changes nothing. A read at any other address returns 0x00. Bits 6:4 are never stored and always read as 0.
- R3: When a port is not routed to USB, its switch-enable output equals its stored bit (bit 0 for port 1, bit 1 for port 2) from the clock edge that stores the write. This holds in every mode, sleep included.
- R4: While card 1 is routed (`usbRoute` = 2'b01), `swEn1` is 0 whatever bit 0 holds, and `swEn2` still follows bit 1.
- R5: While card 2 is routed (`usbRoute` = 2'b10), `swEn2` is 0 whatever bit 1 holds, and `swEn1` still follows bit 0.
- R6: When the device is awake, a select of 01 or 10 routes card 1 or card 2, and a select of 00 routes none. `usbRoute` and `opMode` change on the clock edge after the edge that stores the write.
- R7: While the stored sleep bit is set, `opMode` stays 2'b10 and `usbRoute` stays 2'b00, whatever the select bits are written to.
- R8: On the edge after the stored sleep bit clears, the select value stored at that point takes effect, exactly as in R6.
- R9: A select of 11 leaves `usbRoute` unchanged.
- R10: Card 1 and card 2 are never routed at the same time, so `usbRoute` is never 2'b11.
- R11: A read at address 0x00 returns the stored register, with bit 0 and bit 1 as written, even while a switch output is forced off.
- R12: The `opMode` encoding is 2'b00 for pass-through, 2'b01 for card reader and 2'b10 for sleep. Sleep takes precedence, and 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Register address for reads and writes |
| busWrEn | input | 1 | Write strobe; data is stored on the rising edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data (combinational from `busAddr`) |
| swEn1 | output | 1 | Effective enable for the port 1 switch bank |
| swEn2 | output | 1 | Effective enable for the port 2 switch bank |
| opMode | output | 2 | Operating mode: 00 pass-through, 01 card reader, 10 sleep |
| usbRoute | output | 2 | Card routed to USB: bit 0 card 1, bit 1 card 2 |

## Verification
The bench writes every byte value after several prior register states, covering awake, routed and sleeping states, and samples the outputs after the storing edge and again one edge later. This exposes a design that moves the route in the same cycle as the write, and a design that leaves the switches a cycle late.

Sleep entry, a select written during sleep and wake-up are driven directly. A design that routes a card from inside sleep, or forgets the held select on wake, shows a wrong `opMode` or `usbRoute`.

The reserved select value, writes to foreign addresses and read-back while a switch bit is overridden are also covered. A design that clears the route on 11, decodes other addresses, or returns the overridden switch level instead of the stored bit shows a mismatch.

// File: rtl/cr_mode_pkg.sv
package cr_mode_pkg;

  // Bit positions inside the control byte
  localparam int SW1_BIT   = 0;
  localparam int SW2_BIT   = 1;
  localparam int SEL_LO    = 2;
  localparam int SEL_W     = 2;
  localparam int SLEEP_BIT = 7;

  // Card select codes
  localparam logic [SEL_W-1:0] SEL_NONE  = 2'b00;
  localparam logic [SEL_W-1:0] SEL_CARD1 = 2'b01;
  localparam logic [SEL_W-1:0] SEL_CARD2 = 2'b10;

  typedef enum logic [1:0] {
    MODE_PASS   = 2'b00,
    MODE_READER = 2'b01,
    MODE_SLEEP  = 2'b10
  } opMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic regWr;   // store write data this cycle
    logic rdHit;   // read address decodes to the register
    logic ovr1;    // force port 1 switches off
    logic ovr2;    // force port 2 switches off
  } ctrlStrobe_t;

endpackage

// File: rtl/cr_mode_seq.sv
module cr_mode_seq
  import cr_mode_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              sleepQ,
  input  logic [SEL_W-1:0]  selQ,
  output ctrlStrobe_t       strobe,
  output logic [1:0]        opMode,
  output logic [1:0]        usbRoute
);

  logic             effSleep;
  logic [1:0]       effCard;
  logic [1:0]       routeLive;
  logic             addrHit;
  opMode_e          modeNow;

  assign addrHit = (busAddr == REG_ADDR);

  // Effective state follows the stored register one edge later.
  // The card selection is frozen while the stored sleep bit is set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      effSleep <= 1'b0;
      effCard  <= 2'b00;
    end else begin
      effSleep <= sleepQ;
      if (!sleepQ) begin
        unique case (selQ)
          SEL_NONE:  effCard <= 2'b00;
          SEL_CARD1: effCard <= 2'b01;
          SEL_CARD2: effCard <= 2'b10;
          default:   effCard <= effCard;  // reserved code: hold
        endcase
      end
    end
  end

  assign routeLive = effSleep ? 2'b00 : effCard;

  always_comb begin
    if (effSleep)        modeNow = MODE_SLEEP;
    else if (|routeLive) modeNow = MODE_READER;
    else                 modeNow = MODE_PASS;
  end

  always_comb begin
    strobe.regWr = busWrEn & addrHit;
    strobe.rdHit = addrHit;
    strobe.ovr1  = routeLive[0];
    strobe.ovr2  = routeLive[1];
  end

  assign opMode   = modeNow;
  assign usbRoute = routeLive;

endmodule

// File: rtl/cr_mode_dp.sv
module cr_mode_dp
  import cr_mode_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] regQ,
  output logic [DATA_W-1:0] busRdData,
  output logic              swEn1,
  output logic              swEn2
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] KEEP_MASK =
      (ONE << SW1_BIT) | (ONE << SW2_BIT) |
      (((ONE << SEL_W) - ONE) << SEL_LO) | (ONE << SLEEP_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             regQ <= '0;
    else if (strobe.regWr) regQ <= busWrData & KEEP_MASK;
  end

  // Switch bits act at once; a routed port is forced off
  assign swEn1 = regQ[SW1_BIT] & ~strobe.ovr1;
  assign swEn2 = regQ[SW2_BIT] & ~strobe.ovr2;

  assign busRdData = strobe.rdHit ? regQ : '0;

endmodule

// File: rtl/cr_mode_ctl.sv
module cr_mode_ctl
  import cr_mode_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              swEn1,
  output logic              swEn2,
  output logic [1:0]        opMode,
  output logic [1:0]        usbRoute
);

  ctrlStrobe_t       strobe;
  logic [DATA_W-1:0] regQ;

  cr_mode_seq #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) seq_i (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .sleepQ   (regQ[SLEEP_BIT]),
    .selQ     (regQ[SEL_LO +: SEL_W]),
    .strobe   (strobe),
    .opMode   (opMode),
    .usbRoute (usbRoute)
  );

  cr_mode_dp #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .regQ      (regQ),
    .busRdData (busRdData),
    .swEn1     (swEn1),
    .swEn2     (swEn2)
  );

endmodule

// File: rtl/cr_mode_chk.sv
module cr_mode_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] regQ,
  input logic              swEn1,
  input logic              swEn2,
  input logic [1:0]        opMode,
  input logic [1:0]        usbRoute
);

  assert_port1_forced_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    usbRoute[0] |-> !swEn1);

  assert_port2_forced_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    usbRoute[1] |-> !swEn2);

  assert_port1_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    !usbRoute[0] |-> (swEn1 == regQ[0]));

  assert_port2_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    !usbRoute[1] |-> (swEn2 == regQ[1]));

  assert_route_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(usbRoute));

  assert_mode_legal_R12: assert property (@(posedge clk) disable iff (!rstN)
    opMode != 2'b11);

  assert_sleep_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == 2'b10 && regQ[7]) |=> (opMode == 2'b10 && usbRoute == 2'b00));

  assert_card1_applied_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!regQ[7] && regQ[3:2] == 2'b01) |=> usbRoute == 2'b01);

  assert_reserved_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!regQ[7] && opMode != 2'b10 && regQ[3:2] == 2'b11) |=> $stable(usbRoute));

  assert_foreign_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr != '0) |=> $stable(regQ));

endmodule

bind cr_mode_ctl cr_mode_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .regQ     (regQ),
  .swEn1    (swEn1),
  .swEn2    (swEn2),
  .opMode   (opMode),
  .usbRoute (usbRoute)
);

// File: tb/cr_mode_ctl_tb_top.sv
module cr_mode_ctl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       swEn1, swEn2;
  logic [1:0] opMode, usbRoute;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // Bench model of the requirements
  logic [7:0] mReg = 8'h00;
  logic       mSleep = 1'b0;
  logic [1:0] mCard = 2'b00;

  always #2 clk = ~clk;

  cr_mode_ctl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .swEn1(swEn1),
    .swEn2(swEn2), .opMode(opMode), .usbRoute(usbRoute)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: update model at the edge, return at the falling edge
  task automatic tick();
    @(posedge clk);
    if (!mReg[7]) begin
      case (mReg[3:2])
        2'b00: mCard = 2'b00;
        2'b01: mCard = 2'b01;
        2'b10: mCard = 2'b10;
        default: mCard = mCard;
      endcase
    end
    mSleep = mReg[7];
    if (busWrEn && busAddr == 8'h00) mReg = busWrData & 8'h8F;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0; busAddr = 8'h00;
  endtask

  task automatic checkModel();
    logic [1:0] eRoute;
    logic [1:0] eMode;
    #1;
    eRoute = mSleep ? 2'b00 : mCard;
    eMode  = mSleep ? 2'b10 : ((eRoute != 2'b00) ? 2'b01 : 2'b00);
    chk(eRoute[0] ? "R4" : "R3", swEn1, mReg[0] & ~eRoute[0]);
    chk(eRoute[1] ? "R5" : "R3", swEn2, mReg[1] & ~eRoute[1]);
    chk(mSleep ? "R7" : "R6", usbRoute, eRoute);
    chk("R12", opMode, eMode);
    chk("R11", busRdData, mReg);
    chk("R10", (usbRoute == 2'b11), 0);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired actual=running expected=done");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", busRdData, 8'h00);
    chk("R1", {swEn1, swEn2}, 0);
    chk("R1", opMode, 2'b00);
    chk("R1", usbRoute, 2'b00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R6: route card 1 one edge after the storing edge
    wr(8'h00, 8'h04); #1;
    chk("R6", usbRoute, 2'b00);
    tick(); #1;
    chk("R6", usbRoute, 2'b01);
    chk("R12", opMode, 2'b01);

    // R4: port 1 forced off, port 2 free; R11 read returns stored bits
    wr(8'h00, 8'h07); #1;
    chk("R4", swEn1, 0);
    chk("R4", swEn2, 1);
    chk("R11", busRdData, 8'h07);

    // R5: switch to card 2
    wr(8'h00, 8'h0B); #1;
    chk("R4", {swEn1, swEn2}, 2'b01);
    tick(); #1;
    chk("R5", usbRoute, 2'b10);
    chk("R5", {swEn1, swEn2}, 2'b10);

    // R9: reserved select holds the route
    wr(8'h00, 8'h0F);
    repeat (3) tick();
    #1;
    chk("R9", usbRoute, 2'b10);

    // R7: sleep entry, then selection written in sleep is held
    wr(8'h00, 8'h87);
    tick(); #1;
    chk("R12", opMode, 2'b10);
    chk("R3", {swEn1, swEn2}, 2'b11);
    wr(8'h00, 8'h8B);
    repeat (3) tick();
    #1;
    chk("R7", opMode, 2'b10);
    chk("R7", usbRoute, 2'b00);
    wr(8'h00, 8'h88); #1;
    chk("R3", {swEn1, swEn2}, 2'b00);

    // R8: wake applies the held selection one edge later
    wr(8'h00, 8'h08); #1;
    chk("R8", opMode, 2'b10);
    tick(); #1;
    chk("R8", opMode, 2'b01);
    chk("R8", usbRoute, 2'b10);

    // R2: foreign address write and read, unstored bits
    wr(8'h05, 8'hFF); #1;
    chk("R2", busRdData, 8'h08);
    busAddr = 8'h05; #1;
    chk("R2", busRdData, 8'h00);
    busAddr = 8'h00;
    wr(8'h00, 8'h7F); #1;
    chk("R2", busRdData, 8'h0F);
    tick();

    // Sweep: every byte after several prior states
    for (int p = 0; p < 6; p++) begin
      logic [7:0] prior;
      case (p)
        0: prior = 8'h00;
        1: prior = 8'h04;
        2: prior = 8'h0B;
        3: prior = 8'h80;
        4: prior = 8'h84;
        default: prior = 8'h0C;
      endcase
      for (int v = 0; v < 256; v++) begin
        wr(8'h00, prior);
        tick();
        wr(8'h00, v[7:0]);
        checkModel();
        tick();
        checkModel();
        if (v % 16 == 3) begin
          wr(8'h21, ~v[7:0]);
          checkModel();
        end
      end
    end

    done = 1;
    finishRun();
  end

endmodule